// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time and calendar date in packed BCD. It is clocked by the system clock and gets a one-cycle enable pulse for each cycle of a 32.768 kHz time base. A prescaler turns a parameterised number of those pulses into a one-second advance. Seconds, minutes, hours, day of week, date, month and two-digit year are kept in BCD, with carries between them and month lengths that follow a leap-year rule. Hours count in either 24-hour or 12-hour form, and the register itself selects the form.

Four alarm registers mirror seconds, minutes, hours and day of week. Each one carries a mask bit that takes its field out of the comparison. The compare runs once per advance, on the freshly updated time. A match sets a sticky flag. The flag drives an active-high interrupt output through an enable bit, and any read or write of an alarm register clears it. Software reaches everything through a byte-wide register port with separate read and write strobes. A stop bit in the control register freezes the time.

Top module: `bcd_rtc_alarm`

## Requirements
- R1: After reset the time reads 00 seconds, 00 minutes, hours 00 in 24-hour form, day of week 1, date 01, month 01 and year 00. The control register reads 80h (stopped, interrupt disabled), the status register reads 00h and irq is low.
- R2: While control bit 7 is 1 the time does not advance, whatever tick_32k does. While it is 0, the seconds advance by one for every TICKS_PER_SEC pulses of tick_32k.
- R3: Seconds and minutes count 00 to 59 in BCD, and each wraps to 00 with a carry into the next field. Day of week (address 03h) counts 1 to 7 and wraps to 1 on each day carry.
- R4: Hours register bit 6 selects the mode (1 = 12-hour). In 24-hour mode hours count 00 to 23, with bit 5 as the tens digit of 20 to 23, and 23 wraps to 00 with a day carry.
- R5: In 12-hour mode bits 4:0 hold BCD 12, 01, ..., 11 and bit 5 is PM (1 = PM). PM toggles on the step from 11 to 12. Only the step from 11 PM to 12 AM carries into the date.
- R6: Dates run 1 to 31 in months 01, 03, 05, 07, 08, 10 and 12, and 1 to 30 in months 04, 06, 09 and 11. February runs to 29 when the BCD year is divisible by 4 (00 counts as leap) and to 28 otherwise. Month 12 wraps to 01 with a year carry, and year 99 wraps to 00.
- R7: The address map is: 00h seconds, 01h minutes, 02h hours, 03h day of week, 04h date, 05h month, 06h year, 07h–0Ah alarm seconds/minutes/hours/day, 0Bh control (bit 7 stop, bit 0 interrupt enable), 0Ch status (bit 0 alarm flag). Bits with no meaning and all other addresses read 0 whatever is written.
- R8: Each alarm register holds its field's value in bits 6:0 (day in bits 2:0) with a mask in bit 7. The alarm matches when every field either has its mask set or equals the time field, with the hours compare covering bits 6:0.
- R9: The flag is set only on the cycle that follows a time advance, and only when the updated time matches. After that it holds until a read or write of addresses 07h–0Ah clears it, so a match sets it once per second.
- R10: irq is high exactly while the flag and control bit 0 are both 1.
- R11: A write to the seconds register restarts the prescaler, so the next advance comes a full TICKS_PER_SEC pulses after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable per time-base period |
| reg_sel | input | AW | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (used to clear the alarm flag) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_sel |
| irq | output | 1 | Active-high alarm interrupt |

## Verification
The bench goes after the rollovers where a BCD counter usually slips. It checks 59 to 00 in each field, 23 to 00, the 12-hour steps 11 AM to 12 PM and 11 PM to 12 AM, February in leap and non-leap years including year 00, 30-day months, and the year wrap. A design that got one of these wrong would show a hex digit such as 5Ah, a date of 29 or 31 in the wrong month, or a day carry at noon. On the alarm side the bench covers each mask pattern, a day-of-week mismatch, a PM/AM mismatch in 12-hour mode, and the clear on an alarm read. A design that compared every cycle instead of once per advance would set the flag again just after it was cleared. The bench also confirms that a write to the seconds register resets the phase of the sub-second divider, and that the stop bit freezes the time.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned ADR_SEC  = 0;
  localparam int unsigned ADR_MIN  = 1;
  localparam int unsigned ADR_HR   = 2;
  localparam int unsigned ADR_DOW  = 3;
  localparam int unsigned ADR_DATE = 4;
  localparam int unsigned ADR_MON  = 5;
  localparam int unsigned ADR_YEAR = 6;
  localparam int unsigned ADR_ASEC = 7;
  localparam int unsigned ADR_ADOW = 10;
  localparam int unsigned ADR_CTRL = 11;
  localparam int unsigned ADR_STAT = 12;
  localparam int unsigned N_ALM    = 4;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hr;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] yr;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{sec: 7'h00, min: 7'h00, hr: 7'h00,
                                     dow: 3'd1, date: 6'h01, mon: 5'h01,
                                     yr: 8'h00};

  // Add one to a two-digit packed BCD value (no wrap handling).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Year divisible by four, from its BCD digits.
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  // Last date of a month, in BCD.
  function automatic logic [5:0] month_len(input logic [4:0] mon, input logic [7:0] yr);
    case (mon)
      5'h02:                      return is_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick_in,
  input  logic clr,
  output logic sec_tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          tick_n;

  always_comb begin
    cnt_n  = cnt_q;
    tick_n = 1'b0;
    if (clr || !run) begin
      cnt_n = '0;
    end else if (tick_in) begin
      if (cnt_q == LAST) begin
        cnt_n  = '0;
        tick_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sec_tick <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      sec_tick <= tick_n;
    end
  end
endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
  import rtc_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_sel,
  input  logic [7:0]    wr_data,
  output rtc_time_t     t_q
);
  rtc_time_t t_inc, t_n;
  logic sec_c, min_c, hr_c, date_c, mon_c;

  // Carry chain for one advance
  always_comb begin
    t_inc  = t_q;
    sec_c  = (t_q.sec == 7'h59);
    min_c  = sec_c && (t_q.min == 7'h59);
    hr_c   = 1'b0;
    t_inc.sec = sec_c ? 7'h00 : 7'(bcd_inc({1'b0, t_q.sec}));
    if (sec_c)
      t_inc.min = (t_q.min == 7'h59) ? 7'h00 : 7'(bcd_inc({1'b0, t_q.min}));
    if (min_c) begin
      if (t_q.hr[6]) begin
        case (t_q.hr[4:0])
          5'h12: t_inc.hr = {1'b1, t_q.hr[5], 5'h01};
          5'h11: begin
            t_inc.hr = {1'b1, ~t_q.hr[5], 5'h12};
            hr_c     = t_q.hr[5];
          end
          default: t_inc.hr = {1'b1, t_q.hr[5], 5'(bcd_inc({3'b000, t_q.hr[4:0]}))};
        endcase
      end else begin
        if (t_q.hr[5:0] == 6'h23) begin
          t_inc.hr = 7'h00;
          hr_c     = 1'b1;
        end else begin
          t_inc.hr = {1'b0, 6'(bcd_inc({2'b00, t_q.hr[5:0]}))};
        end
      end
    end
    date_c = hr_c && (t_q.date == month_len(t_q.mon, t_q.yr));
    mon_c  = date_c && (t_q.mon == 5'h12);
    if (hr_c) begin
      t_inc.dow  = (t_q.dow == 3'd7) ? 3'd1 : t_q.dow + 3'd1;
      t_inc.date = date_c ? 6'h01 : 6'(bcd_inc({2'b00, t_q.date}));
    end
    if (date_c)
      t_inc.mon = mon_c ? 5'h01 : 5'(bcd_inc({3'b000, t_q.mon}));
    if (mon_c)
      t_inc.yr = (t_q.yr == 8'h99) ? 8'h00 : bcd_inc(t_q.yr);
  end

  // Register writes take priority over the advance for their field
  always_comb begin
    t_n = adv ? t_inc : t_q;
    if (wr_en) begin
      case (wr_sel)
        AW'(ADR_SEC):  t_n.sec  = wr_data[6:0];
        AW'(ADR_MIN):  t_n.min  = wr_data[6:0];
        AW'(ADR_HR):   t_n.hr   = wr_data[6:0];
        AW'(ADR_DOW):  t_n.dow  = wr_data[2:0];
        AW'(ADR_DATE): t_n.date = wr_data[5:0];
        AW'(ADR_MON):  t_n.mon  = wr_data[4:0];
        AW'(ADR_YEAR): t_n.yr   = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_q <= TIME_RST;
    else        t_q <= t_n;
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [AW-1:0]         sel,
  input  logic [7:0]            wr_data,
  input  rtc_time_t             t_cur,
  output logic [N_ALM-1:0][7:0] alm_q,
  output logic                  irqf
);
  logic [6:0]       cur [N_ALM];
  logic [N_ALM-1:0] hit;
  logic             acc, irqf_n;

  assign cur[0] = t_cur.sec;
  assign cur[1] = t_cur.min;
  assign cur[2] = t_cur.hr;
  assign cur[3] = {4'b0000, t_cur.dow};

  for (genvar i = 0; i < N_ALM; i++) begin : g_fld
    localparam logic [7:0] WMASK = (i == N_ALM - 1) ? 8'h87 : 8'hFF;
    logic [7:0] q, n;
    always_comb begin
      n = q;
      if (wr_en && (sel == AW'(ADR_ASEC + i))) n = wr_data & WMASK;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 8'h00;
      else        q <= n;
    end
    assign hit[i]   = q[7] || (q[6:0] == cur[i]);
    assign alm_q[i] = q;
  end

  assign acc = (wr_en || rd_en) && (sel >= AW'(ADR_ASEC)) && (sel <= AW'(ADR_ADOW));

  always_comb begin
    irqf_n = irqf;
    if (upd && (&hit)) irqf_n = 1'b1;
    else if (acc)      irqf_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqf <= 1'b0;
    else        irqf <= irqf_n;
  end
endmodule

// File: rtl/bcd_rtc_alarm.sv
module bcd_rtc_alarm
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned AW            = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_32k,
  input  logic [AW-1:0] reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq
);
  rtc_time_t             t_q;
  logic [N_ALM-1:0][7:0] alm_q;
  logic sec_tick, upd_q, irqf;
  logic osc_stop_q, osc_stop_n, aie_q, aie_n;
  logic sec_wr, ctrl_wr;

  assign sec_wr  = reg_wr && (reg_sel == AW'(ADR_SEC));
  assign ctrl_wr = reg_wr && (reg_sel == AW'(ADR_CTRL));

  rtc_prescaler #(.DIV(TICKS_PER_SEC)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(!osc_stop_q), .tick_in(tick_32k),
    .clr(sec_wr), .sec_tick(sec_tick)
  );

  rtc_timekeep #(.AW(AW)) u_time (
    .clk(clk), .rst_n(rst_n), .adv(sec_tick), .wr_en(reg_wr),
    .wr_sel(reg_sel), .wr_data(reg_wdata), .t_q(t_q)
  );

  rtc_alarm #(.AW(AW)) u_alarm (
    .clk(clk), .rst_n(rst_n), .upd(upd_q), .wr_en(reg_wr), .rd_en(reg_rd),
    .sel(reg_sel), .wr_data(reg_wdata), .t_cur(t_q), .alm_q(alm_q), .irqf(irqf)
  );

  always_comb begin
    osc_stop_n = ctrl_wr ? reg_wdata[7] : osc_stop_q;
    aie_n      = ctrl_wr ? reg_wdata[0] : aie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_stop_q <= 1'b1;
      aie_q      <= 1'b0;
      upd_q      <= 1'b0;
    end else begin
      osc_stop_q <= osc_stop_n;
      aie_q      <= aie_n;
      upd_q      <= sec_tick;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_sel)
      AW'(ADR_SEC):      reg_rdata = {1'b0, t_q.sec};
      AW'(ADR_MIN):      reg_rdata = {1'b0, t_q.min};
      AW'(ADR_HR):       reg_rdata = {1'b0, t_q.hr};
      AW'(ADR_DOW):      reg_rdata = {5'b0, t_q.dow};
      AW'(ADR_DATE):     reg_rdata = {2'b0, t_q.date};
      AW'(ADR_MON):      reg_rdata = {3'b0, t_q.mon};
      AW'(ADR_YEAR):     reg_rdata = t_q.yr;
      AW'(ADR_ASEC):     reg_rdata = alm_q[0];
      AW'(ADR_ASEC + 1): reg_rdata = alm_q[1];
      AW'(ADR_ASEC + 2): reg_rdata = alm_q[2];
      AW'(ADR_ADOW):     reg_rdata = alm_q[3];
      AW'(ADR_CTRL):     reg_rdata = {osc_stop_q, 6'b0, aie_q};
      AW'(ADR_STAT):     reg_rdata = {7'b0, irqf};
      default:           reg_rdata = 8'h00;
    endcase
  end

  assign irq = irqf && aie_q;
endmodule

// File: rtl/rtc_sva.sv
module rtc_sva #(
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [AW-1:0] reg_sel,
  input logic [6:0]    sec_q,
  input logic          sec_tick,
  input logic          upd,
  input logic          irqf,
  input logic          osc_stop
);
  logic sec_write, alm_acc;
  assign sec_write = reg_wr && (reg_sel == AW'(0));
  assign alm_acc   = (reg_wr || reg_rd) && (reg_sel >= AW'(7)) && (reg_sel <= AW'(10));

  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop && !sec_tick && !sec_write) |=> $stable(sec_q)); // R2

  AST_SEC_MOVES_ON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !sec_write) |=> $stable(sec_q)); // R2

  AST_PRESC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sec_write |=> !sec_tick); // R11

  AST_FLAG_SET_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irqf && !upd) |=> !irqf); // R9

  AST_FLAG_CLEAR_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_acc && !upd) |=> !irqf); // R9
endmodule

bind bcd_rtc_alarm rtc_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
  .sec_q(t_q.sec), .sec_tick(sec_tick), .upd(upd_q), .irqf(irqf),
  .osc_stop(osc_stop_q)
);

// File: tb/bcd_rtc_alarm_tb.sv
module bcd_rtc_alarm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 4;
  localparam int AW         = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_32k = 1'b0;
  logic [AW-1:0] reg_sel = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  int ms, mm, mh, mdw, mdt, mmo, myr;
  bit m12;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc_alarm #(.TICKS_PER_SEC(TPS), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hr_reg(input int h, input bit twelve);
    int h12;
    if (!twelve) return to_bcd(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return 8'h40 | ((h >= 12) ? 8'h20 : 8'h00) | to_bcd(h12);
  endfunction

  task automatic model_step();
    ms++;
    if (ms == 60) begin ms = 0; mm++; end
    if (mm == 60) begin
      mm = 0; mh++;
      if (mh == 24) begin
        mh = 0;
        mdw = (mdw % 7) + 1;
        mdt++;
        if (mdt > dim(mmo, myr)) begin
          mdt = 1; mmo++;
          if (mmo == 13) begin mmo = 1; myr = (myr + 1) % 100; end
        end
      end
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp_v);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = AW'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_sel = AW'(a); reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_32k = 1'b1;
    end
    @(negedge clk);
    tick_32k = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic adv_sec(input int n);
    ticks(n * TPS);
    for (int i = 0; i < n; i++) model_step();
  endtask

  task automatic load_time();
    wr(2, hr_reg(mh, m12));
    wr(1, to_bcd(mm));
    wr(3, 8'(mdw));
    wr(4, to_bcd(mdt));
    wr(5, to_bcd(mmo));
    wr(6, to_bcd(myr));
    wr(0, to_bcd(ms));
  endtask

  task automatic set_all(input int yr, input int mo, input int dt, input int dw,
                         input int h, input int mi, input int s, input bit twelve);
    myr = yr; mmo = mo; mdt = dt; mdw = dw; mh = h; mm = mi; ms = s; m12 = twelve;
    load_time();
  endtask

  task automatic check_time(input string req);
    logic [7:0] d;
    rd(0, d); chk(req, d, to_bcd(ms));
    rd(1, d); chk(req, d, to_bcd(mm));
    rd(2, d); chk(req, d, hr_reg(mh, m12));
    rd(3, d); chk(req, d, 8'(mdw));
    rd(4, d); chk(req, d, to_bcd(mdt));
    rd(5, d); chk(req, d, to_bcd(mmo));
    rd(6, d); chk(req, d, to_bcd(myr));
  endtask

  task automatic chk_flag(input string req, input logic exp_v);
    logic [7:0] d;
    rd(12, d);
    chk(req, d, {7'b0, exp_v});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    set_all(0, 1, 1, 1, 0, 0, 0, 0);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    check_time("R1");
    rd(11, d); chk("R1 ctrl", d, 8'h80);
    rd(12, d); chk("R1 status", d, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2: stopped clock ignores ticks, then runs
    ticks(5 * TPS);
    check_time("R2 stopped");
    wr(11, 8'h00);
    adv_sec(3);
    check_time("R2 running");

    // R3: seconds/minutes/dow rollovers
    set_all(23, 6, 14, 7, 23, 59, 58, 0);
    adv_sec(1); check_time("R3 59s");
    adv_sec(1); check_time("R3 dow wrap");
    set_all(23, 6, 14, 2, 10, 9, 59, 0);
    adv_sec(1); check_time("R3 min carry");

    // R4: 24-hour mode
    set_all(23, 6, 14, 2, 19, 59, 59, 0);
    adv_sec(1); check_time("R4 19->20");

    // R5: 12-hour mode
    set_all(23, 3, 10, 5, 11, 59, 59, 1);
    adv_sec(1); check_time("R5 11AM->12PM");
    set_all(23, 3, 10, 5, 23, 59, 59, 1);
    adv_sec(1); check_time("R5 11PM->12AM");
    set_all(23, 3, 10, 5, 0, 59, 59, 1);
    adv_sec(1); check_time("R5 12AM->1AM");
    set_all(23, 3, 10, 5, 12, 59, 59, 1);
    adv_sec(1); check_time("R5 12PM->1PM");

    // R6: month lengths and leap years
    set_all(24, 2, 28, 3, 23, 59, 59, 0);
    adv_sec(1); check_time("R6 leap feb28");
    set_all(24, 2, 29, 4, 23, 59, 59, 0);
    adv_sec(1); check_time("R6 feb29");
    set_all(23, 2, 28, 4, 23, 59, 59, 0);
    adv_sec(1); check_time("R6 nonleap");
    set_all(0, 2, 28, 4, 23, 59, 59, 0);
    adv_sec(1); check_time("R6 year00");
    set_all(23, 4, 30, 4, 23, 59, 59, 1);
    adv_sec(1); check_time("R6 apr30");
    set_all(99, 12, 31, 6, 23, 59, 59, 0);
    adv_sec(1); check_time("R6 year wrap");

    // R7: unused bits and addresses
    wr(3, 8'hFF); rd(3, d); chk("R7 dow bits", d, 8'h07);
    wr(4, 8'hFF); rd(4, d); chk("R7 date bits", d, 8'h3F);
    wr(11, 8'h7E); rd(11, d); chk("R7 ctrl bits", d, 8'h00);
    wr(10, 8'h7F); rd(10, d); chk("R7 alarm dow bits", d, 8'h07);
    wr(15, 8'hFF); rd(15, d); chk("R7 empty addr", d, 8'h00);

    // R11: seconds write restarts prescaler
    set_all(23, 5, 5, 1, 8, 0, 10, 0);
    ticks(TPS - 1);
    wr(0, to_bcd(ms));
    ticks(TPS - 1);
    check_time("R11 no advance yet");
    ticks(1); model_step();
    check_time("R11 advance after full second");

    // R8/R9/R10: all masks set -> every second
    wr(11, 8'h00);
    wr(7, 8'h80); wr(8, 8'h80); wr(9, 8'h80); wr(10, 8'h80);
    chk_flag("R9 cleared by write", 1'b0);
    adv_sec(1);
    chk_flag("R8 every second", 1'b1);
    chk("R10 irq disabled", {7'b0, irq}, 8'h00);
    wr(11, 8'h01);
    chk("R10 irq enabled", {7'b0, irq}, 8'h01);
    rd(8, d);
    chk_flag("R9 cleared by read", 1'b0);
    chk("R10 irq low after clear", {7'b0, irq}, 8'h00);

    // R8/R9: seconds match only, set once
    wr(7, 8'h30);
    set_all(23, 5, 5, 1, 8, 0, 28, 0);
    rd(7, d);
    adv_sec(1); chk_flag("R8 sec mismatch", 1'b0);
    adv_sec(1); chk_flag("R8 sec match", 1'b1);
    rd(7, d);
    repeat (6) @(negedge clk);
    chk_flag("R9 once per second", 1'b0);

    // R8: full match including day
    wr(7, 8'h00); wr(8, 8'h00); wr(9, 8'h07); wr(10, 8'h03);
    set_all(23, 5, 5, 2, 6, 59, 59, 0);
    rd(7, d);
    adv_sec(1); chk_flag("R8 day mismatch", 1'b0);
    set_all(23, 5, 5, 3, 6, 59, 59, 0);
    adv_sec(1); chk_flag("R8 full match", 1'b1);

    // R8: day masked, 12-hour PM compare
    wr(9, 8'h61); wr(10, 8'h80);
    set_all(23, 5, 5, 3, 0, 59, 59, 1);
    adv_sec(1); chk_flag("R8 AM vs PM", 1'b0);
    set_all(23, 5, 5, 3, 12, 59, 59, 1);
    adv_sec(1); chk_flag("R8 1PM match", 1'b1);
    chk("R10 irq", {7'b0, irq}, 8'h01);
    rd(9, d);

    // R3..R6: random start times
    for (int it = 0; it < 24; it++) begin
      int yr, mo;
      yr = int'($urandom % 100); mo = 1 + int'($urandom % 12);
      set_all(yr, mo, 1 + int'($urandom % dim(mo, yr)), 1 + int'($urandom % 7),
              int'($urandom % 24), 55 + int'($urandom % 5),
              56 + int'($urandom % 4), bit'($urandom % 2));
      adv_sec(1 + int'($urandom % 4));
      check_time("R3-random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule